// File: doc/BRIEF.md
# Serial Paged Memory Access Engine

This block is the serial slave front end for a small 64-byte register array. A bus master lowers chip select, clocks in a command byte and a start-address byte, and then either streams data bytes into the array or streams them out of it. The engine moves the data between the serial pins and a byte-wide port to the array: a 6-bit address, a write strobe, write data and combinational read data. The array itself lives outside the block.

The serial pins are oversampled by the block's own clock. Each pin passes through a two-stage synchronizer, and clock edges are found from the synchronized serial clock. The serial clock therefore has to stay high and low for at least four system clock cycles in each phase. A single pointer register holds the array address. On a read it counts through the whole 64-byte space. On a write it counts only within the current 8-byte page.

Top module: `spi_paged_mem_engine`

## Requirements
- R1: Bit 0 of the first byte after chip select falls selects the operation: 1 is a read and 0 is a write. Bits 7 to 1 of that byte have no effect.
- R2: Serial input bits are taken on the rising serial clock edge, and each byte is assembled most significant bit first.
- R3: On a read, the first data bit appears after the first falling serial clock edge that follows the rising edge that samples bit 0 of the address byte. Each later falling edge presents the next bit, most significant bit first, and bytes keep coming until chip select rises.
- R4: The pointer loads from bits 5 to 0 of the second byte and advances by one for each data byte. Bits 7 and 6 of the address byte are ignored.
- R5: On a read, the pointer goes from 3Fh to 00h and keeps counting.
- R6: On a write, only pointer bits 2 to 0 advance, going from 7 to 0. Bits 5 to 3 (the page) stay fixed for the whole transfer, so six bytes sent to address 5 land at 5, 6, 7, 0, 1 and 2 of that page.
- R7: A write of more than 8 data bytes keeps going around the page, and each later byte replaces the earlier one at the same location.
- R8: Each complete data byte of a write produces exactly one single-cycle write strobe, carrying that byte and its target address. No strobe is produced on a read or for the command and address bytes.
- R9: A partly received byte is dropped when chip select rises and causes no write. The next transfer starts again with a fresh command byte.
- R10: The output enable is low, and serial data out is high-Z, while chip select is high, and also during any transfer that is not a read in its data phase. The enable drops within three clocks after chip select rises.
- R11: After reset, the output enable and the write strobe are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Serial chip select, active low |
| sck | input | 1 | Serial clock from the master |
| sdi | input | 1 | Serial data from the master |
| sdo | output | 1 | Serial data to the master, high-Z when not enabled |
| sdo_oe | output | 1 | High while sdo is being driven |
| mem_addr | output | 6 | Array address, the current pointer |
| mem_we | output | 1 | Single-cycle array write strobe |
| mem_wdata | output | 8 | Byte to be written |
| mem_rdata | input | 8 | Array read data for mem_addr, combinational |

## Verification
A serial clock edge reaches the logic after two synchronizer stages plus one edge-detect stage. So a read bit settles on sdo about four system clocks after a falling serial edge, and the write strobe comes about four to five clocks after the rising edge that completes a byte. The bench holds each serial phase for eight system clocks. It samples sdo at the end of the low phase, just before it raises the serial clock. It checks array contents and strobe counts only after chip select has risen and four more serial half-periods have passed. The output enable is checked after the same settling time.

// File: rtl/spi_pe_pkg.sv
package spi_pe_pkg;
  typedef enum logic [1:0] {
    ST_CMD  = 2'd0,
    ST_ADDR = 2'd1,
    ST_WR   = 2'd2,
    ST_RD   = 2'd3
  } pe_state_e;

  localparam int RW_BIT = 0;
endpackage

// File: rtl/spi_pe_sync.sv
module spi_pe_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] pipe_q, pipe_d;

  always_comb begin
    pipe_d = {pipe_q[STAGES-2:0], d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= {STAGES{RST_VAL}};
    else        pipe_q <= pipe_d;
  end

  assign q = pipe_q[STAGES-1];
endmodule

// File: rtl/spi_pe_rx.sv
module spi_pe_rx #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              rise,
  input  logic              din,
  output logic              byte_done,
  output logic [DATA_W-1:0] byte_val
);
  localparam int CNT_W = $clog2(DATA_W);

  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [DATA_W-1:0] sh_q, sh_d;
  logic              done_q, done_d;

  always_comb begin
    cnt_d  = cnt_q;
    sh_d   = sh_q;
    done_d = 1'b0;
    if (clr) begin
      cnt_d = '0;
    end else if (rise) begin
      sh_d   = {sh_q[DATA_W-2:0], din};
      cnt_d  = cnt_q + CNT_W'(1);
      done_d = (cnt_q == CNT_W'(DATA_W - 1));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      sh_q   <= '0;
      done_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      sh_q   <= sh_d;
      done_q <= done_d;
    end
  end

  assign byte_done = done_q;
  assign byte_val  = sh_q;

  // R9: chip select high discards any partial frame
  p_frame_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0));
  // R2: a finished byte is flagged only once per frame
  p_done_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !done_d);
endmodule

// File: rtl/spi_pe_tx.sv
module spi_pe_tx #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              fall,
  input  logic              en,
  input  logic [DATA_W-1:0] load_data,
  output logic              load,
  output logic              bit_out
);
  localparam int CNT_W = $clog2(DATA_W);

  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [DATA_W-1:0] sh_q, sh_d;
  logic              bit_q, bit_d;

  assign load = fall && en && (cnt_q == '0);

  always_comb begin
    cnt_d = cnt_q;
    sh_d  = sh_q;
    bit_d = bit_q;
    if (clr || !en) begin
      cnt_d = '0;
    end else if (fall) begin
      cnt_d = cnt_q + CNT_W'(1);
      if (cnt_q == '0) begin
        bit_d = load_data[DATA_W-1];
        sh_d  = {load_data[DATA_W-2:0], 1'b0};
      end else begin
        bit_d = sh_q[DATA_W-1];
        sh_d  = {sh_q[DATA_W-2:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sh_q  <= '0;
      bit_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      sh_q  <= sh_d;
      bit_q <= bit_d;
    end
  end

  assign bit_out = bit_q;

  // R3: the first bit of each byte is the byte's MSB
  p_load_msb_r3: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (bit_q == $past(load_data[DATA_W-1])));
  // R3: the output bit only changes on a falling serial edge
  p_bit_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !fall |=> $stable(bit_q));
endmodule

// File: rtl/spi_paged_mem_engine.sv
module spi_paged_mem_engine
  import spi_pe_pkg::*;
#(
  parameter int ADDR_W      = 6,
  parameter int OFFS_W      = 3,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sck,
  input  logic              sdi,
  output logic              sdo,
  output logic              sdo_oe,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata
);
  localparam int PAGE_W = ADDR_W - OFFS_W;

  // reset: asynchronous assertion, synchronous release
  logic [1:0] rst_pipe_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_core_n = rst_pipe_q[1];

  // pin synchronizers and edge detection
  logic cs_s, sck_s, sdi_s, sck_d;
  logic rise, fall;

  spi_pe_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_cs (
    .clk(clk), .rst_n(rst_core_n), .d(cs_n), .q(cs_s));
  spi_pe_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sck (
    .clk(clk), .rst_n(rst_core_n), .d(sck), .q(sck_s));
  spi_pe_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sdi (
    .clk(clk), .rst_n(rst_core_n), .d(sdi), .q(sdi_s));

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) sck_d <= 1'b0;
    else             sck_d <= sck_s;
  end

  assign rise = sck_s && !sck_d && !cs_s;
  assign fall = !sck_s && sck_d && !cs_s;

  // byte framing
  logic              byte_done;
  logic [DATA_W-1:0] byte_val;
  logic              tx_load;
  logic              tx_bit;

  spi_pe_rx #(.DATA_W(DATA_W)) u_rx (
    .clk(clk), .rst_n(rst_core_n), .clr(cs_s), .rise(rise), .din(sdi_s),
    .byte_done(byte_done), .byte_val(byte_val));

  // control and pointer
  pe_state_e         state_q, state_d;
  logic              rw_q, rw_d;
  logic [ADDR_W-1:0] ptr_q, ptr_d;
  logic              we_q, we_d;
  logic [DATA_W-1:0] wdata_q, wdata_d;

  spi_pe_tx #(.DATA_W(DATA_W)) u_tx (
    .clk(clk), .rst_n(rst_core_n), .clr(cs_s), .fall(fall),
    .en(state_q == ST_RD), .load_data(mem_rdata), .load(tx_load),
    .bit_out(tx_bit));

  always_comb begin
    state_d = state_q;
    rw_d    = rw_q;
    ptr_d   = ptr_q;
    we_d    = 1'b0;
    wdata_d = wdata_q;
    if (we_q)
      ptr_d = {ptr_q[ADDR_W-1:OFFS_W], ptr_q[OFFS_W-1:0] + OFFS_W'(1)};
    if (tx_load)
      ptr_d = ptr_q + ADDR_W'(1);
    if (cs_s) begin
      state_d = ST_CMD;
    end else if (byte_done) begin
      case (state_q)
        ST_CMD: begin
          rw_d    = byte_val[RW_BIT];
          state_d = ST_ADDR;
        end
        ST_ADDR: begin
          ptr_d   = byte_val[ADDR_W-1:0];
          state_d = rw_q ? ST_RD : ST_WR;
        end
        ST_WR: begin
          we_d    = 1'b1;
          wdata_d = byte_val;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      state_q <= ST_CMD;
      rw_q    <= 1'b0;
      ptr_q   <= '0;
      we_q    <= 1'b0;
      wdata_q <= '0;
    end else begin
      state_q <= state_d;
      rw_q    <= rw_d;
      ptr_q   <= ptr_d;
      we_q    <= we_d;
      wdata_q <= wdata_d;
    end
  end

  assign mem_addr  = ptr_q;
  assign mem_we    = we_q;
  assign mem_wdata = wdata_q;
  assign sdo_oe    = (state_q == ST_RD);
  assign sdo       = sdo_oe ? tx_bit : 1'bz;

  // R8: the write strobe lasts one clock
  p_we_pulse_r8: assert property (@(posedge clk) disable iff (!rst_core_n)
    mem_we |=> !mem_we);
  // R10: output released once chip select is high
  p_oe_cs_r10: assert property (@(posedge clk) disable iff (!rst_core_n)
    ($past(cs_s) && cs_s) |-> !sdo_oe);
  // R6: the page bits stay fixed through a write
  p_page_hold_r6: assert property (@(posedge clk) disable iff (!rst_core_n)
    (state_q == ST_WR && $past(state_q == ST_WR)) |->
      (mem_addr[ADDR_W-1:ADDR_W-PAGE_W] == $past(mem_addr[ADDR_W-1:ADDR_W-PAGE_W])));
  // R4, R5: each byte loaded on a read advances the address by one, modulo 64
  p_rd_step_r5: assert property (@(posedge clk) disable iff (!rst_core_n)
    (state_q == ST_RD && $past(state_q == ST_RD) && $past(tx_load)) |->
      (mem_addr == $past(mem_addr) + ADDR_W'(1)));
  // R8: no strobe outside the data phase of a write
  p_we_wr_only_r8: assert property (@(posedge clk) disable iff (!rst_core_n)
    mem_we |-> (state_q == ST_WR));
endmodule

// File: tb/sim_spi_paged_mem_engine.sv
`timescale 1ns/1ps
module sim_spi_paged_mem_engine;
  localparam int HALF = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1;
  logic       sck = 1'b0;
  logic       sdi = 1'b0;
  logic       sdo, sdo_oe, mem_we;
  logic [5:0] mem_addr;
  logic [7:0] mem_wdata, mem_rdata;

  logic [7:0] mem [64];
  logic [7:0] ref_mem [64];
  int checks = 0;
  int failures = 0;
  int we_count = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  spi_paged_mem_engine u0 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .sdi(sdi),
    .sdo(sdo), .sdo_oe(sdo_oe), .mem_addr(mem_addr), .mem_we(mem_we),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata));

  assign mem_rdata = mem[mem_addr];
  always @(posedge clk) begin
    if (mem_we) begin
      mem[mem_addr] <= mem_wdata;
      we_count <= we_count + 1;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xfer_bits(input logic [7:0] tx, input int nbits, output logic [7:0] rx);
    rx = '0;
    for (int i = 7; i > 7 - nbits; i--) begin
      sdi = tx[i];
      wait_clk(HALF);
      rx[i] = sdo;
      sck = 1'b1;
      wait_clk(HALF);
      sck = 1'b0;
    end
  endtask

  task automatic cs_begin();
    cs_n = 1'b0;
    wait_clk(HALF);
  endtask

  task automatic cs_end();
    wait_clk(HALF);
    cs_n = 1'b1;
    wait_clk(4 * HALF);
  endtask

  task automatic compare_mem(input string req);
    int bad = 0;
    int first = -1;
    for (int i = 0; i < 64; i++) begin
      if (mem[i] !== ref_mem[i]) begin
        bad++;
        if (first < 0) first = i;
      end
    end
    check(bad == 0, req, bad, 0);
    if (bad != 0) $display("  first mismatch at %0h: %0h vs %0h", first, mem[first], ref_mem[first]);
  endtask

  function automatic logic [5:0] wr_loc(input logic [5:0] a, input int k);
    logic [2:0] off;
    off = a[2:0] + 3'(k);
    return {a[5:3], off};
  endfunction

  task automatic do_write(input logic [5:0] a, input int n, input string req);
    logic [7:0] rx, b;
    int base;
    cs_begin();
    xfer_bits({7'($urandom), 1'b0}, 8, rx);
    xfer_bits({2'($urandom), a}, 8, rx);
    base = we_count;
    for (int k = 0; k < n; k++) begin
      b = 8'($urandom);
      xfer_bits(b, 8, rx);
      ref_mem[wr_loc(a, k)] = b;
      if (k == 0) check(sdo_oe == 1'b0, "R10 oe during write", int'(sdo_oe), 0);
    end
    cs_end();
    check(we_count - base == n, "R8 strobe count", we_count - base, n);
    compare_mem(req);
  endtask

  task automatic do_read(input logic [5:0] a, input int n, input string req);
    logic [7:0] rx, exp;
    cs_begin();
    xfer_bits({7'($urandom), 1'b1}, 8, rx);
    xfer_bits({2'($urandom), a}, 8, rx);
    for (int k = 0; k < n; k++) begin
      xfer_bits(8'h00, 8, rx);
      exp = ref_mem[6'(int'(a) + k)];
      check(rx == exp, req, rx, exp);
      if (k == 0) check(sdo_oe == 1'b1, "R3 oe in read", int'(sdo_oe), 1);
    end
    cs_end();
    check(sdo_oe == 1'b0, "R10 oe after cs", int'(sdo_oe), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog act=running exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] rx;
    int base;
    void'($urandom(32'd1234));
    for (int i = 0; i < 64; i++) begin
      mem[i] = 8'(i * 7 + 3);
      ref_mem[i] = 8'(i * 7 + 3);
    end
    wait_clk(5);
    check(sdo_oe == 1'b0, "R11 oe in reset", int'(sdo_oe), 0);
    check(mem_we == 1'b0, "R11 we in reset", int'(mem_we), 0);
    rst_n = 1'b1;
    wait_clk(10);
    check(sdo_oe == 1'b0, "R11 oe after reset", int'(sdo_oe), 0);

    // directed corner cases
    do_write(6'h05, 6, "R6 page wrap at 5");
    do_read(6'h05, 3, "R2 read back low run");
    do_read(6'h00, 3, "R4 read back wrapped run");
    do_write(6'h1A, 11, "R7 overwrite past 8");
    do_read(6'h18, 8, "R7 page contents");
    do_read(6'h3E, 4, "R5 read wrap 3F to 00");
    do_write(6'h3F, 2, "R6 page wrap at 3F");
    do_read(6'h38, 8, "R3 top page read");

    // R9: partial byte then chip select high
    base = we_count;
    cs_begin();
    xfer_bits(8'h00, 8, rx);
    xfer_bits(8'h10, 8, rx);
    xfer_bits(8'hA5, 5, rx);
    cs_end();
    check(we_count == base, "R9 no strobe on partial", we_count - base, 0);
    compare_mem("R9 array unchanged");
    do_read(6'h10, 2, "R9 fresh frame after abort");

    // R10: abort a read in the middle of a byte
    cs_begin();
    xfer_bits(8'hFF, 8, rx);
    xfer_bits(8'h22, 8, rx);
    xfer_bits(8'h00, 8, rx);
    check(rx == ref_mem[6'h22], "R3 first byte before abort", rx, ref_mem[6'h22]);
    xfer_bits(8'h00, 4, rx);
    cs_end();
    check(sdo_oe == 1'b0, "R10 oe after read abort", int'(sdo_oe), 0);

    // constrained random mix
    for (int t = 0; t < 30; t++) begin
      logic [5:0] a;
      int n;
      a = 6'($urandom);
      n = 1 + int'($urandom % 10);
      if ($urandom % 2 == 0) do_write(a, n, "R1 random write");
      else                   do_read(a, n, "R1 random read");
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule